// File: doc/BRIEF.md
# Conditional Memory Ordering Decision Unit

This unit sits inside one processor of a small multiprocessor and carries out a conditional synchronization instruction when a lock is acquired. The operand is the lockword value read at that acquire, called the release number. The unit splits it into the id of the processor that last released the lock and the release count that processor held at the time. The unit keeps a local mirror of every processor's release count. This mirror is advanced by broadcasts from the interconnect. The unit compares the operand against the mirror and its own processor id, and from that it picks one of three outcomes: no ordering, a local acquire fence only, or a remote release request followed by a local acquire fence.

The remote path sends a one-cycle request naming the processor that last released the lock. It then waits for the broadcast that advances that processor's mirror entry. After that broadcast it raises the local acquire fence request and waits for the fence hardware to acknowledge it. The unit also outputs its own current release number, which software stores in the lockword when it releases a lock. Only one instruction is in flight at a time. Requests that arrive while the unit is busy are dropped.

Top module: `cmo_order_unit`

## Requirements
- R1: After reset, req_ready is 1. busy, done, rmt_req and acq_req are 0, outcome is 3'b000, and every mirror entry is 0, so local_relnum equals {my_pid, 30'd0}.
- R2: The release number is 32 bits. Bits [31:30] hold the processor id and bits [29:0] hold the release count.
- R3: When an accepted operand's id equals my_pid, done is high for one cycle starting in the cycle after acceptance, with outcome 3'b001. Neither rmt_req nor acq_req is raised.
- R4: When the ids differ and the operand count differs from the mirror entry for the operand id, acq_req rises in the cycle after acceptance and stays high until acq_ack is sampled. done follows in the next cycle with outcome 3'b010, and rmt_req is never raised.
- R5: When the ids differ and the operand count equals the mirror entry for the operand id, rmt_req is a one-cycle pulse in the cycle after acceptance, and rmt_pid carries the operand id.
- R6: After a remote request, acq_req rises only in the cycle after a broadcast naming the target id. A broadcast naming any other id does not end the wait. After acq_ack, done is given with outcome 3'b100.
- R7: Each broadcast adds one, modulo 2^30, to the mirror entry it names and leaves all other entries unchanged. local_relnum is {my_pid, mirror entry of my_pid}.
- R8: When a broadcast and an accepted request fall in the same cycle, the decision uses the mirror value held before that broadcast.
- R9: While busy is high, req_ready is low and req_valid is ignored: it produces no done, no rmt_req and no change of outcome.
- R10: When done is high, outcome has exactly one bit set. When done is low, outcome is 3'b000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| my_pid | input | 2 | Id of this processor |
| req_valid | input | 1 | Instruction request |
| req_relnum | input | 32 | Release-number operand |
| req_ready | output | 1 | Unit idle and able to accept |
| busy | output | 1 | Instruction in flight |
| done | output | 1 | One-cycle completion pulse |
| outcome | output | 3 | One-hot result: 001 none, 010 local, 100 remote |
| rmt_req | output | 1 | Remote release request pulse |
| rmt_pid | output | 2 | Target processor of the remote request |
| acq_req | output | 1 | Local acquire fence request |
| acq_ack | input | 1 | Fence hardware acknowledge |
| bcast_valid | input | 1 | Release-count broadcast arrives |
| bcast_pid | input | 2 | Processor whose count advances |
| local_relnum | output | 32 | Own release number for the lockword |

## Verification
A mirror increment and a decision can fall on the same clock edge. The hazard is the case where the broadcast names the very processor whose entry the operand is compared against. The bench provokes this by driving a broadcast in the same cycle as a request whose count matches the entry's old value. It then expects a remote request, not a local-only fence. A second overlap is a foreign broadcast and a dropped request arriving during a remote wait; the bench judges that case by the absence of any fence request, any done pulse and any new remote request.

// File: rtl/cmo_pkg.sv
package cmo_pkg;
    localparam int NPROC = 4;
    localparam int PID_W = 2;
    localparam int RN_W  = 32;
    localparam int CTR_W = RN_W - PID_W;

    typedef logic [PID_W-1:0] pid_t;
    typedef logic [CTR_W-1:0] ctr_t;

    // processor id occupies the top bits, release count the rest
    typedef struct packed {
        pid_t pid;
        ctr_t ctr;
    } relnum_t;

    typedef enum logic [2:0] {
        OC_NONE   = 3'b001,
        OC_LOCAL  = 3'b010,
        OC_REMOTE = 3'b100
    } outcome_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_FENCE
    } st_e;

    function automatic relnum_t split_relnum(input logic [RN_W-1:0] v);
        return relnum_t'(v);
    endfunction
endpackage

// File: rtl/cmo_relvec.sv
module cmo_relvec
    import cmo_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bcast_valid,
    input  pid_t bcast_pid,
    input  pid_t rd_pid,
    input  pid_t my_pid,
    output ctr_t rd_ctr,
    output ctr_t my_ctr
);
    ctr_t vec [NPROC];

    for (genvar g = 0; g < NPROC; g++) begin : g_ent
        localparam pid_t ID = pid_t'(g);
        always_ff @(posedge clk) begin
            if (rst)
                vec[g] <= '0;
            else if (bcast_valid && bcast_pid == ID)
                vec[g] <= vec[g] + 1'b1;
        end

        a_r7_inc: assert property (@(posedge clk) disable iff (rst)
            (bcast_valid && bcast_pid == ID) |=> vec[g] == ctr_t'($past(vec[g]) + 1'b1));
        a_r7_keep: assert property (@(posedge clk) disable iff (rst)
            !(bcast_valid && bcast_pid == ID) |=> $stable(vec[g]));
    end

    assign rd_ctr = vec[rd_pid];
    assign my_ctr = vec[my_pid];
endmodule

// File: rtl/cmo_decide.sv
module cmo_decide
    import cmo_pkg::*;
(
    input  relnum_t  op,
    input  pid_t     my_pid,
    input  ctr_t     entry,
    output outcome_e dec
);
    always_comb begin
        if (op.pid == my_pid)
            dec = OC_NONE;
        else if (op.ctr == entry)
            dec = OC_REMOTE;
        else
            dec = OC_LOCAL;
    end
endmodule

// File: rtl/cmo_seq.sv
module cmo_seq
    import cmo_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     req_valid,
    input  outcome_e dec,
    input  pid_t     op_pid,
    input  logic     acq_ack,
    input  logic     bcast_valid,
    input  pid_t     bcast_pid,
    output logic     req_ready,
    output logic     busy,
    output logic     done,
    output logic [2:0] outcome,
    output logic     rmt_req,
    output pid_t     rmt_pid,
    output logic     acq_req
);
    st_e      state;
    logic     done_q;
    logic     rmt_q;
    outcome_e oc_q;
    pid_t     tgt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            done_q <= 1'b0;
            rmt_q  <= 1'b0;
            oc_q   <= OC_NONE;
            tgt    <= '0;
        end else begin
            done_q <= 1'b0;
            rmt_q  <= 1'b0;
            case (state)
                ST_IDLE: if (req_valid) begin
                    oc_q <= dec;
                    tgt  <= op_pid;
                    case (dec)
                        OC_NONE:   done_q <= 1'b1;
                        OC_LOCAL:  state  <= ST_FENCE;
                        OC_REMOTE: begin
                            state <= ST_WAIT;
                            rmt_q <= 1'b1;
                        end
                        default:   state  <= ST_IDLE;
                    endcase
                end
                ST_WAIT: if (bcast_valid && bcast_pid == tgt)
                    state <= ST_FENCE;
                ST_FENCE: if (acq_ack) begin
                    state  <= ST_IDLE;
                    done_q <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign req_ready = (state == ST_IDLE);
    assign busy      = !req_ready;
    assign acq_req   = (state == ST_FENCE);
    assign done      = done_q;
    assign outcome   = done_q ? oc_q : 3'b000;
    assign rmt_req   = rmt_q;
    assign rmt_pid   = tgt;

    a_r3_fast: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && dec == OC_NONE) |=> (done && outcome == OC_NONE));
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (acq_req && !acq_ack) |=> acq_req);
    a_r5_pulse: assert property (@(posedge clk) disable iff (rst)
        rmt_req |=> !rmt_req);
    a_r6_wait: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && !(bcast_valid && bcast_pid == tgt)) |=> !acq_req);
    a_r9_src: assert property (@(posedge clk) disable iff (rst)
        rmt_req |-> $past(req_valid && req_ready));
    a_r10_onehot: assert property (@(posedge clk) disable iff (rst)
        done |-> $countones(outcome) == 1);
endmodule

// File: rtl/cmo_order_unit.sv
module cmo_order_unit
    import cmo_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [PID_W-1:0] my_pid,
    input  logic            req_valid,
    input  logic [RN_W-1:0] req_relnum,
    output logic            req_ready,
    output logic            busy,
    output logic            done,
    output logic [2:0]      outcome,
    output logic            rmt_req,
    output logic [PID_W-1:0] rmt_pid,
    output logic            acq_req,
    input  logic            acq_ack,
    input  logic            bcast_valid,
    input  logic [PID_W-1:0] bcast_pid,
    output logic [RN_W-1:0] local_relnum
);
    relnum_t  op;
    ctr_t     rd_ctr;
    ctr_t     my_ctr;
    outcome_e dec;

    assign op = split_relnum(req_relnum);

    cmo_relvec u_vec (
        .clk        (clk),
        .rst        (rst),
        .bcast_valid(bcast_valid),
        .bcast_pid  (bcast_pid),
        .rd_pid     (op.pid),
        .my_pid     (my_pid),
        .rd_ctr     (rd_ctr),
        .my_ctr     (my_ctr)
    );

    cmo_decide u_dec (
        .op    (op),
        .my_pid(my_pid),
        .entry (rd_ctr),
        .dec   (dec)
    );

    cmo_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .dec        (dec),
        .op_pid     (op.pid),
        .acq_ack    (acq_ack),
        .bcast_valid(bcast_valid),
        .bcast_pid  (bcast_pid),
        .req_ready  (req_ready),
        .busy       (busy),
        .done       (done),
        .outcome    (outcome),
        .rmt_req    (rmt_req),
        .rmt_pid    (rmt_pid),
        .acq_req    (acq_req)
    );

    assign local_relnum = {my_pid, my_ctr};
endmodule

// File: tb/sim_cmo_order_unit.sv
`timescale 1ns/1ps
module sim_cmo_order_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  my_pid = 2'd1;
    logic        req_valid = 1'b0;
    logic [31:0] req_relnum = '0;
    logic        req_ready, busy, done, rmt_req, acq_req;
    logic [2:0]  outcome;
    logic [1:0]  rmt_pid;
    logic        acq_ack = 1'b0;
    logic        bcast_valid = 1'b0;
    logic [1:0]  bcast_pid = '0;
    logic [31:0] local_relnum;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    cmo_order_unit u0 (
        .clk(clk), .rst(rst), .my_pid(my_pid),
        .req_valid(req_valid), .req_relnum(req_relnum),
        .req_ready(req_ready), .busy(busy), .done(done), .outcome(outcome),
        .rmt_req(rmt_req), .rmt_pid(rmt_pid), .acq_req(acq_req), .acq_ack(acq_ack),
        .bcast_valid(bcast_valid), .bcast_pid(bcast_pid), .local_relnum(local_relnum)
    );

    // {pid[31:30], count[29:0], expected outcome}; mirror starts at zero, my_pid = 1
    localparam logic [34:0] TBL [8] = '{
        {2'd1, 30'd5, 3'b001},
        {2'd2, 30'd0, 3'b100},
        {2'd2, 30'd0, 3'b010},
        {2'd2, 30'd1, 3'b100},
        {2'd0, 30'd7, 3'b010},
        {2'd3, 30'd0, 3'b100},
        {2'd1, 30'd0, 3'b001},
        {2'd0, 30'd0, 3'b100}
    };

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_req(input logic [31:0] rn, input logic [2:0] exp,
                           input bit same_bc, input logic [1:0] bc_pid, input string tag);
        bit seen = 0;
        bit fin = 0;
        @(negedge clk);
        req_valid  = 1'b1;
        req_relnum = rn;
        if (same_bc) begin
            bcast_valid = 1'b1;
            bcast_pid   = bc_pid;
        end
        @(negedge clk);
        req_valid   = 1'b0;
        bcast_valid = 1'b0;
        for (int n = 0; n < 60 && !fin; n++) begin
            if (n > 0) begin
                @(negedge clk);
                bcast_valid = 1'b0;
                acq_ack     = 1'b0;
            end
            if (rmt_req) begin
                seen = 1;
                chk(rmt_pid == rn[31:30], {tag, " R5 rmt_pid"}, rmt_pid, rn[31:30]);
                chk(n == 0, {tag, " R5 pulse timing"}, n, 0);
                bcast_valid = 1'b1;
                bcast_pid   = rmt_pid;
            end
            if (acq_req) acq_ack = 1'b1;
            if (done) begin
                fin = 1;
                chk(outcome == exp, {tag, " R2 outcome"}, outcome, exp);
                if (exp == 3'b001) chk(n == 0, {tag, " R3 done timing"}, n, 0);
            end
        end
        chk(fin, {tag, " done seen"}, fin, 1);
        chk(seen == (exp == 3'b100), {tag, " remote request seen"}, seen, exp == 3'b100);
        @(negedge clk);
        acq_ack     = 1'b0;
        bcast_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
        chk(busy == 1'b0 && done == 1'b0, "R1 busy/done", {busy, done}, 0);
        chk(rmt_req == 1'b0 && acq_req == 1'b0, "R1 rmt/acq", {rmt_req, acq_req}, 0);
        chk(outcome == 3'b000, "R1 outcome R10", outcome, 0);
        chk(local_relnum == {2'd1, 30'd0}, "R1 local_relnum", local_relnum, {2'd1, 30'd0});

        // table walk: R3 none, R4 local, R6 remote
        for (int i = 0; i < 8; i++) begin
            string tg;
            tg = (TBL[i][2:0] == 3'b001) ? "R3" : (TBL[i][2:0] == 3'b010) ? "R4" : "R6";
            run_req(TBL[i][34:3], TBL[i][2:0], 1'b0, 2'd0, tg);
        end
        // mirror now: p0=1 p1=0 p2=2 p3=1

        // R7: own entry advanced by broadcasts
        @(negedge clk); bcast_valid = 1'b1; bcast_pid = 2'd1;
        @(negedge clk); bcast_pid = 2'd1;
        @(negedge clk); bcast_valid = 1'b0;
        chk(local_relnum == {2'd1, 30'd2}, "R7 local_relnum", local_relnum, {2'd1, 30'd2});
        chk(done == 1'b0 && outcome == 3'b000, "R10 idle outcome", outcome, 0);

        // R6 + R9: remote wait with foreign broadcast and a dropped request
        @(negedge clk); req_valid = 1'b1; req_relnum = {2'd0, 30'd1};
        @(negedge clk); req_valid = 1'b0;
        chk(rmt_req == 1'b1 && rmt_pid == 2'd0, "R5 direct remote", {rmt_req, rmt_pid}, 3'b100);
        bcast_valid = 1'b1; bcast_pid = 2'd2;
        req_valid = 1'b1; req_relnum = {2'd1, 30'd0};
        @(negedge clk); bcast_valid = 1'b0; req_valid = 1'b0;
        chk(busy == 1'b1 && req_ready == 1'b0, "R9 busy", {busy, req_ready}, 2'b10);
        chk(acq_req == 1'b0, "R6 foreign bcast", acq_req, 0);
        chk(done == 1'b0, "R9 no done", done, 0);
        @(negedge clk);
        chk(done == 1'b0 && rmt_req == 1'b0, "R9 ignored req", {done, rmt_req}, 0);
        bcast_valid = 1'b1; bcast_pid = 2'd0;
        @(negedge clk); bcast_valid = 1'b0;
        chk(acq_req == 1'b1, "R6 fence after target bcast", acq_req, 1);
        acq_ack = 1'b1;
        @(negedge clk); acq_ack = 1'b0;
        chk(done == 1'b1 && outcome == 3'b100, "R6 remote done", {done, outcome}, 4'b1100);
        // mirror now: p0=2 p2=3 p3=1

        // R8: same-cycle broadcast to the compared entry uses the old value
        run_req({2'd3, 30'd1}, 3'b100, 1'b1, 2'd3, "R8");

        // R4: fence held until acknowledge
        @(negedge clk); req_valid = 1'b1; req_relnum = {2'd2, 30'd0};
        @(negedge clk); req_valid = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk(acq_req == 1'b1 && done == 1'b0 && rmt_req == 1'b0, "R4 fence held",
                {acq_req, done, rmt_req}, 3'b100);
            @(negedge clk);
        end
        acq_ack = 1'b1;
        @(negedge clk); acq_ack = 1'b0;
        chk(done == 1'b1 && outcome == 3'b010, "R4 local done", {done, outcome}, 4'b1010);
        @(negedge clk);
        chk(done == 1'b0 && req_ready == 1'b1, "R3 single done pulse", {done, req_ready}, 2'b01);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule